// File: doc/BRIEF.md
# Signaling Change-of-State Detector

This block follows the four-bit signaling value (bits A, B, C and D) of every receive channel and tells a host when a value has changed. Upstream logic writes each channel's latest nibble into a staging slot whenever it likes. A multiframe strobe commits all staging slots at the same moment, and each commit is compared with the channel's stored reference value.

An optional global integration mode filters out short signaling glitches. In that mode a new value becomes a change only after it has been committed unchanged on three multiframes in a row. Every change sets a per-channel status bit. A per-channel enable mask decides which channels may also set a latched summary bit. The summary bit, gated by an interrupt mask, drives an active-low interrupt. The host clears status bits by pulsing write-one-to-clear strobes.

Top module: `sigcos_detect`

## Requirements
- R1: A staging write (`sig_valid` high with `sig_chan` and `sig_data`) has no visible effect until a cycle in which `mf_strobe` is high. That commit uses the staged values as they were before that cycle.
- R2: After reset, the first commit of each channel only loads that channel's reference value and sets no status bit.
- R3: With `integ_en` low, a commit whose value differs from a channel's reference sets `chan_chg[c]` in the cycle after the strobe and makes the new value the reference. A commit equal to the reference sets nothing.
- R4: With `integ_en` high, a differing value sets `chan_chg[c]` only on the third consecutive commit of that same value, one cycle after that strobe. Later commits of the same value set nothing. The mode applies to all channels at once.
- R5: With `integ_en` high, the count restarts if a commit brings a different candidate. A commit equal to the reference cancels the pending candidate.
- R6: `chan_chg[c]` is set by every change, whatever the value of `chg_en[c]`.
- R7: `sum_chg` is set in the cycle after a strobe only if at least one channel with `chg_en` high changed on that strobe. It stays set when `chg_en` later drops.
- R8: `irq_n` is low exactly when both `sum_chg` and `irq_mask` are high.
- R9: `clr_chan[c]` clears `chan_chg[c]` and `clr_sum` clears `sum_chg` in the next cycle, and other bits are left as they were. A change in the same cycle as a clear wins, and the bit stays set.
- R10: During and right after reset, `chan_chg` is all zeros, `sum_chg` is 0 and `irq_n` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| mf_strobe | input | 1 | Multiframe boundary; commits all staging slots |
| sig_valid | input | 1 | Staging write enable |
| sig_chan | input | CH_W | Channel index of the staging write |
| sig_data | input | 4 | Signaling nibble of the staging write |
| integ_en | input | 1 | Global three-multiframe integration mode |
| chg_en | input | NCH | Channels allowed to set the summary bit |
| irq_mask | input | 1 | Lets the summary bit drive the interrupt |
| clr_chan | input | NCH | Write-one-to-clear strobes for the per-channel status bits |
| clr_sum | input | 1 | Write-one-to-clear strobe for the summary bit |
| chan_chg | output | NCH | Latched per-channel change status |
| sum_chg | output | 1 | Latched summary change status |
| irq_n | output | 1 | Active-low interrupt |

## Verification
The assertions assume that `mf_strobe` is the only cause of a new status bit. They also assume the control inputs `chg_en`, `irq_mask` and the clear strobes are held at defined levels from reset onward. The stimulus drives every input on the falling clock edge with known values and raises the strobe for exactly one cycle per multiframe. It never writes a staging slot in the same cycle as a strobe. The interrupt assertion relies on `irq_mask` changing only between strobes, which the sweep respects.

// File: rtl/sigcos_pkg.sv
package sigcos_pkg;
  localparam int SIG_W = 4;
  typedef logic [SIG_W-1:0] sig_nib_t;
endpackage

// File: rtl/sigcos_chan.sv
module sigcos_chan
  import sigcos_pkg::*;
#(
  parameter int INTEG_MF = 3
) (
  input  logic     clk,
  input  logic     rst_n,
  input  logic     wr_en,
  input  sig_nib_t wr_data,
  input  logic     commit,
  input  logic     integ_en,
  output logic     hit
);
  localparam int CNT_W = $clog2(INTEG_MF + 1);
  localparam logic [CNT_W-1:0] CNT_ONE  = CNT_W'(1);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(INTEG_MF - 1);

  sig_nib_t         stage_q, ref_q, cand_q;
  sig_nib_t         ref_d, cand_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             primed_q;

  // next-state evaluation at a commit
  always_comb begin
    ref_d  = ref_q;
    cand_d = cand_q;
    cnt_d  = cnt_q;
    hit    = 1'b0;
    if (commit) begin
      if (!primed_q) begin
        ref_d  = stage_q;
        cand_d = stage_q;
        cnt_d  = '0;
      end else if (!integ_en) begin
        cand_d = stage_q;
        cnt_d  = '0;
        if (stage_q != ref_q) begin
          ref_d = stage_q;
          hit   = 1'b1;
        end
      end else if (stage_q == ref_q) begin
        cand_d = ref_q;
        cnt_d  = '0;
      end else if (stage_q != cand_q) begin
        cand_d = stage_q;
        cnt_d  = CNT_ONE;
      end else if (cnt_q == CNT_LAST) begin
        ref_d = stage_q;
        cnt_d = '0;
        hit   = 1'b1;
      end else begin
        cnt_d = cnt_q + CNT_ONE;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_q  <= '0;
      ref_q    <= '0;
      cand_q   <= '0;
      cnt_q    <= '0;
      primed_q <= 1'b0;
    end else begin
      if (wr_en) stage_q <= wr_data;
      if (commit) begin
        ref_q    <= ref_d;
        cand_q   <= cand_d;
        cnt_q    <= cnt_d;
        primed_q <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/sigcos_status.sv
module sigcos_status #(
  parameter int NCH = 32
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [NCH-1:0] hit,
  input  logic [NCH-1:0] chg_en,
  input  logic [NCH-1:0] clr_chan,
  input  logic           clr_sum,
  input  logic           irq_mask,
  output logic [NCH-1:0] chan_chg,
  output logic           sum_chg,
  output logic           irq_n
);
  logic [NCH-1:0] chan_d;
  logic           sum_d;

  // a new change outranks a clear in the same cycle
  always_comb begin
    chan_d = (chan_chg & ~clr_chan) | hit;
    sum_d  = (sum_chg & ~clr_sum) | (|(hit & chg_en));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chan_chg <= '0;
      sum_chg  <= 1'b0;
    end else begin
      chan_chg <= chan_d;
      sum_chg  <= sum_d;
    end
  end

  assign irq_n = ~(sum_chg & irq_mask);
endmodule

// File: rtl/sigcos_detect.sv
module sigcos_detect
  import sigcos_pkg::*;
#(
  parameter int NCH      = 32,
  parameter int INTEG_MF = 3,
  parameter int CH_W     = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            mf_strobe,
  input  logic            sig_valid,
  input  logic [CH_W-1:0] sig_chan,
  input  logic [3:0]      sig_data,
  input  logic            integ_en,
  input  logic [NCH-1:0]  chg_en,
  input  logic            irq_mask,
  input  logic [NCH-1:0]  clr_chan,
  input  logic            clr_sum,
  output logic [NCH-1:0]  chan_chg,
  output logic            sum_chg,
  output logic            irq_n
);
  logic [1:0]     rst_sync_q;
  logic           rst_int_n;
  logic [NCH-1:0] hit;

  // asynchronous assertion, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  for (genvar gi = 0; gi < NCH; gi++) begin : g_chan
    logic wr_sel;
    assign wr_sel = sig_valid && (sig_chan == CH_W'(gi));
    sigcos_chan #(.INTEG_MF(INTEG_MF)) chan_i (
      .clk      (clk),
      .rst_n    (rst_int_n),
      .wr_en    (wr_sel),
      .wr_data  (sig_data),
      .commit   (mf_strobe),
      .integ_en (integ_en),
      .hit      (hit[gi])
    );
  end

  sigcos_status #(.NCH(NCH)) status_i (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .hit      (hit),
    .chg_en   (chg_en),
    .clr_chan (clr_chan),
    .clr_sum  (clr_sum),
    .irq_mask (irq_mask),
    .chan_chg (chan_chg),
    .sum_chg  (sum_chg),
    .irq_n    (irq_n)
  );
endmodule

// File: rtl/sigcos_checker.sv
module sigcos_checker #(
  parameter int NCH = 32
) (
  input logic           clk,
  input logic           rst_n,
  input logic           mf_strobe,
  input logic [NCH-1:0] chg_en,
  input logic [NCH-1:0] clr_chan,
  input logic           clr_sum,
  input logic           irq_mask,
  input logic [NCH-1:0] chan_chg,
  input logic           sum_chg,
  input logic           irq_n
);
  p_chan_only_at_mf_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(mf_strobe) |-> ((chan_chg & ~$past(chan_chg)) == '0));

  p_sum_needs_enabled_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sum_chg) |-> ($past(mf_strobe) && (|(chan_chg & $past(chg_en)))));

  p_sum_holds_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (sum_chg && !clr_sum) |=> sum_chg);

  p_irq_source_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !irq_n |-> (sum_chg && irq_mask));

  p_sum_cleared_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(clr_sum) && !$past(mf_strobe)) |-> !sum_chg);

  p_chan_cleared_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(mf_strobe) |-> ((chan_chg & $past(clr_chan)) == '0));
endmodule

bind sigcos_detect sigcos_checker #(.NCH(NCH)) chk_i (
  .clk      (clk),
  .rst_n    (rst_n),
  .mf_strobe(mf_strobe),
  .chg_en   (chg_en),
  .clr_chan (clr_chan),
  .clr_sum  (clr_sum),
  .irq_mask (irq_mask),
  .chan_chg (chan_chg),
  .sum_chg  (sum_chg),
  .irq_n    (irq_n)
);

// File: tb/sigcos_detect_tb.sv
module sigcos_detect_tb_top;
  localparam int NCH  = 4;
  localparam int CH_W = 2;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            mf_strobe = 1'b0;
  logic            sig_valid = 1'b0;
  logic [CH_W-1:0] sig_chan = '0;
  logic [3:0]      sig_data = '0;
  logic            integ_en = 1'b0;
  logic [NCH-1:0]  chg_en = '0;
  logic            irq_mask = 1'b0;
  logic [NCH-1:0]  clr_chan = '0;
  logic            clr_sum = 1'b0;
  logic [NCH-1:0]  chan_chg;
  logic            sum_chg;
  logic            irq_n;

  int nchk = 0;
  int nerr = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  sigcos_detect #(.NCH(NCH), .INTEG_MF(3)) dut_i (
    .clk(clk), .rst_n(rst_n), .mf_strobe(mf_strobe), .sig_valid(sig_valid),
    .sig_chan(sig_chan), .sig_data(sig_data), .integ_en(integ_en),
    .chg_en(chg_en), .irq_mask(irq_mask), .clr_chan(clr_chan),
    .clr_sum(clr_sum), .chan_chg(chan_chg), .sum_chg(sum_chg), .irq_n(irq_n)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic stage(input int ch, input logic [3:0] v);
    @(negedge clk);
    sig_valid = 1'b1; sig_chan = CH_W'(ch); sig_data = v;
    @(negedge clk);
    sig_valid = 1'b0;
  endtask

  task automatic commit();
    @(negedge clk); mf_strobe = 1'b1;
    @(negedge clk); mf_strobe = 1'b0;
  endtask

  task automatic clear_all();
    @(negedge clk); clr_chan = '1; clr_sum = 1'b1;
    @(negedge clk); clr_chan = '0; clr_sum = 1'b0;
  endtask

  initial begin
    #2000000;
    if (!done) begin
      nerr++; nchk++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
    end
  end

  initial begin
    logic [3:0] r1v;
    repeat (3) @(negedge clk);
    chk("R10 chan_chg in reset", 32'(chan_chg), 0);
    chk("R10 sum_chg in reset", 32'(sum_chg), 0);
    chk("R10 irq_n in reset", 32'(irq_n), 1);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R10 chan_chg after reset", 32'(chan_chg), 0);

    // R2: first commit only primes the references
    chg_en = '1; irq_mask = 1'b1;
    for (int c = 0; c < NCH; c++) stage(c, 4'(c + 9));
    commit();
    chk("R2 first commit silent", 32'(chan_chg), 0);
    chk("R2 first commit sum", 32'(sum_chg), 0);

    // R1: staging alone does nothing
    stage(0, 4'h3);
    repeat (5) @(negedge clk);
    chk("R1 stage without strobe", 32'(chan_chg), 0);
    commit();
    chk("R1 commit after stage", 32'(chan_chg), 32'h1);
    clear_all();
    chk("R9 clear all", 32'(chan_chg), 0);

    // R3/R6/R7/R8 sweep over all old/new value pairs
    for (int a = 0; a < 16; a++) begin
      for (int b = 0; b < 16; b++) begin
        int ch;
        bit diff, en, expsum;
        ch = (a + b) % NCH;
        chg_en = NCH'(a * 5 + b);
        irq_mask = b[0];
        stage(ch, 4'(a)); commit(); clear_all();
        stage(ch, 4'(b)); commit();
        diff = (a != b);
        en = chg_en[ch];
        expsum = diff && en;
        chk("R3 R6 chan_chg", 32'(chan_chg), diff ? (32'h1 << ch) : 0);
        chk("R7 sum_chg", 32'(sum_chg), 32'(expsum));
        chk("R8 irq_n", 32'(irq_n), 32'(!(expsum && irq_mask)));
        clear_all();
      end
    end

    // R4: integration needs three consecutive multiframes
    integ_en = 1'b1; chg_en = '1; irq_mask = 1'b1;
    stage(1, 4'h5); commit(); commit(); commit(); clear_all();
    stage(1, 4'hA);
    commit(); chk("R4 one multiframe", 32'(chan_chg), 0);
    commit(); chk("R4 two multiframes", 32'(chan_chg), 0);
    commit(); chk("R4 third multiframe", 32'(chan_chg), 32'h2);
    clear_all();
    commit(); chk("R4 no repeat", 32'(chan_chg), 0);

    // R5: candidate restart
    stage(1, 4'h6); commit();
    stage(1, 4'h7); commit(); commit();
    chk("R5 restarted count", 32'(chan_chg), 0);
    commit(); chk("R5 change after restart", 32'(chan_chg), 32'h2);
    clear_all();
    // R5: return to reference cancels
    r1v = 4'h7;
    stage(1, 4'hC); commit();
    stage(1, r1v); commit();
    stage(1, 4'hC); commit(); commit();
    chk("R5 cancel by reference", 32'(chan_chg), 0);
    commit(); chk("R5 change after cancel", 32'(chan_chg), 32'h2);
    clear_all();

    // R9: set beats clear, partial clear
    integ_en = 1'b0; chg_en = 4'b0100;
    stage(2, 4'h0);
    @(negedge clk); mf_strobe = 1'b1; clr_chan = '1; clr_sum = 1'b1;
    @(negedge clk); mf_strobe = 1'b0; clr_chan = '0; clr_sum = 1'b0;
    chk("R9 set beats clear chan", 32'(chan_chg), 32'h4);
    chk("R9 set beats clear sum", 32'(sum_chg), 1);
    chg_en = '0;
    repeat (2) @(negedge clk);
    chk("R7 sum held after mask drop", 32'(sum_chg), 1);
    stage(3, 4'h1); commit();
    chk("R6 disabled channel status", 32'(chan_chg), 32'hC);
    @(negedge clk); clr_chan = 4'b0100;
    @(negedge clk); clr_chan = '0;
    chk("R9 partial clear", 32'(chan_chg), 32'h8);
    chk("R9 sum untouched", 32'(sum_chg), 1);
    irq_mask = 1'b0; @(negedge clk);
    chk("R8 masked irq", 32'(irq_n), 1);
    irq_mask = 1'b1; @(negedge clk);
    chk("R8 unmasked irq", 32'(irq_n), 0);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end
endmodule